// File: doc/BRIEF.md
# Miss Handling Entry with Deferred Targets

This block is one miss-tracking slot of a write-back cache. It remembers a single outstanding block miss: its block address, its ready time and order stamp, and the requests (targets) that wait on it. Targets live in two bounded queues. The primary queue holds requests the in-flight fetch will satisfy. The deferred queue holds requests that must wait for a later re-request. The deferred queue is used when ownership is not coming back, when a snoop will take the block away, or when earlier requests are already deferred.

A controller drives one operation per cycle on `op_valid`/`op_code`. Target pushes arrive on a valid/ready stream. The push side is back-pressured (`tgt_ready` low) in any cycle that carries an operation. Otherwise it is always ready, and a push into a full queue is dropped and flagged. Targets leave the primary queue in arrival order on a second valid/ready stream. `out_valid` is held low during operation cycles, and a target is consumed on a cycle where `out_valid` and `out_ready` are both high. Snoop effects enter only as operations that set flags or rewrite upgrade commands.

Command codes: 0 read, 1 read-exclusive, 2 upgrade, 3 store-conditional upgrade, 4 store-conditional, 5 store-conditional-upgrade-fail, 6 store-conditional-fail, 7 hardware prefetch. Source tags: 0 CPU, 1 snoop, 2 prefetcher. Operation codes: 0 allocate, 1 mark in service, 2 fill, 3 promote, 4 deallocate, 5 invalidating snoop, 6 sharing snoop, 7 replace upgrades in both queues, 8 set downstream-pending, 9 clear downstream-pending. Every operation and push takes effect at the clock edge, and its results show on the outputs one cycle later.

Top module: `miss_entry`

## Requirements
- R1: After reset, both queues are empty, every status flag and summary bit is 0, `err` is 0 and `out_valid` is 0.
- R2: Allocate (op 0) records `alloc_addr`, takes `tgt_time`/`tgt_order` as the entry's ready time and order, and clears in-service and downstream-pending. It pushes the `tgt_*` target into the primary queue with source tag 2 when its command is 7 and source tag 0 otherwise.
- R3: A pushed target with source other than 1 goes to the deferred queue when the entry is in service and at least one of these holds: the deferred queue is non-empty, post-invalidate is set, or the target needs exclusive access while pending-dirty is clear, post-downgrade is set or the entry is a forward. Every other pushed target goes to the primary queue.
- R4: A target deferred while post-invalidate is set is rewritten before it is stored: 2 becomes 1, 3 becomes 5, 4 becomes 6, and other codes are unchanged.
- R5: Each queue has a sticky needs-exclusive bit, set by a stored target with source other than 1 and exclusive set. Each queue also has a sticky has-upgrade bit, set by a stored target with source other than 1 and command 2, 3 or 4. Snoop-sourced targets change neither bit.
- R6: Replacing upgrades rewrites every stored command as in R4 and clears has-upgrade. Op 7 does this for both queues, and op 5 does it for the deferred queue. When has-upgrade is already clear, the queue's contents are left unchanged.
- R7: Op 1 on an entry that is not in service and not a no-response forward sets in-service. It sets pending-dirty to the primary needs-exclusive bit OR `svc_dirty`, and clears post-invalidate and post-downgrade.
- R8: Op 1 on a forward allocated with `alloc_noresp` set removes its single target, pulses `fwd_done` for one cycle and leaves in-service clear.
- R9: A fill (op 2) with `fill_shared` low, both post flags clear and the deferred needs-exclusive bit set appends all deferred targets to the primary queue in order. It then sets primary needs-exclusive and empties the deferred queue and resets its flags. Any other fill changes neither queue.
- R10: Promote (op 3) acts only when the primary queue is empty and the deferred queue is not. It moves the deferred targets and summary bits into the primary queue and empties the deferred queue. The entry order becomes the head target's order, and the ready time becomes the larger of `now_time` and the head's ready time. Otherwise it changes nothing.
- R11: Deallocate (op 4) acts only when the primary queue is empty. It clears in-service and the primary summary bits. Otherwise it changes nothing.
- R12: Each queue holds DEPTH (8) targets. A push into a full queue is dropped and sets `err`, which stays set until reset.
- R13: `tgt_ready` and `out_valid` are low in any cycle with `op_valid` high. Targets leave the primary queue in the order they were stored.
- R14: Op 8 sets downstream-pending and op 9 clears it. Ops 5 and 6 set post-invalidate and post-downgrade respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code |
| alloc_addr | input | ADDR_W | Block address for allocate |
| alloc_fwd | input | 1 | Allocated entry is a forward |
| alloc_noresp | input | 1 | Forward expects no response |
| svc_dirty | input | 1 | Dirty response expected, used by op 1 |
| fill_shared | input | 1 | Fill arrived with shared asserted |
| now_time | input | TIME_W | Current time, used by promote |
| tgt_valid | input | 1 | Target push valid |
| tgt_ready | output | 1 | Target push accepted |
| tgt_cmd | input | 3 | Target command code |
| tgt_excl | input | 1 | Target needs exclusive access |
| tgt_src | input | 2 | Target source tag |
| tgt_time | input | TIME_W | Target ready time |
| tgt_order | input | ORD_W | Target order stamp |
| out_valid | output | 1 | Primary head target available |
| out_ready | input | 1 | Consumer takes the head target |
| out_cmd | output | 3 | Head command |
| out_excl | output | 1 | Head exclusive bit |
| out_src | output | 2 | Head source tag |
| out_time | output | TIME_W | Head ready time |
| out_order | output | ORD_W | Head order stamp |
| in_service | output | 1 | Request issued downstream |
| pending_dirty | output | 1 | Ownership expected with the fill |
| post_inval | output | 1 | Block will be invalidated after fill |
| post_downgr | output | 1 | Block will be downgraded after fill |
| ds_pending | output | 1 | Request still buffered downstream |
| fwd_done | output | 1 | One-cycle pulse: no-response forward completed |
| err | output | 1 | Sticky queue overflow |
| blk_addr | output | ADDR_W | Recorded block address |
| entry_time | output | TIME_W | Entry ready time |
| entry_order | output | ORD_W | Entry order stamp |
| prim_count | output | CW | Primary queue occupancy |
| def_count | output | CW | Deferred queue occupancy |
| prim_excl | output | 1 | Primary needs-exclusive bit |
| prim_upg | output | 1 | Primary has-upgrade bit |
| def_excl | output | 1 | Deferred needs-exclusive bit |
| def_upg | output | 1 | Deferred has-upgrade bit |

## Verification
Routing is tried with pushes before service, with an exclusive push while ownership is not expected, with a plain push behind an already deferred one, and with pushes after a sharing snoop and after an invalidating snoop. Together these cases separate each term of the deferral condition, and the last one also shows the upgrade rewrite. Snoop-sourced and CPU-sourced upgrades are pushed in turn, so that the sticky summary bits and the skip-when-clear rule of the rewrite can be told apart. Fills are tried both with the merge condition met and with a post flag set, and promotion is tried on both an occupied and an empty primary queue. The final case overfills the primary queue to show that stored targets keep their order and the extra push is dropped.

// File: rtl/miss_pkg.sv
package miss_pkg;
  parameter int TIME_W = 16;
  parameter int ORD_W  = 8;

  localparam logic [2:0] CMD_READ        = 3'd0;
  localparam logic [2:0] CMD_READ_EX     = 3'd1;
  localparam logic [2:0] CMD_UPG         = 3'd2;
  localparam logic [2:0] CMD_SC_UPG      = 3'd3;
  localparam logic [2:0] CMD_SC          = 3'd4;
  localparam logic [2:0] CMD_SC_UPG_FAIL = 3'd5;
  localparam logic [2:0] CMD_SC_FAIL     = 3'd6;
  localparam logic [2:0] CMD_HWPF        = 3'd7;

  localparam logic [1:0] SRC_CPU   = 2'd0;
  localparam logic [1:0] SRC_SNOOP = 2'd1;
  localparam logic [1:0] SRC_PREF  = 2'd2;

  typedef enum logic [3:0] {
    OP_ALLOC    = 4'd0,
    OP_SERVICE  = 4'd1,
    OP_FILL     = 4'd2,
    OP_PROMOTE  = 4'd3,
    OP_DEALLOC  = 4'd4,
    OP_SNP_INV  = 4'd5,
    OP_SNP_SHR  = 4'd6,
    OP_REPL_ALL = 4'd7,
    OP_DSP_SET  = 4'd8,
    OP_DSP_CLR  = 4'd9
  } op_e;

  typedef struct packed {
    logic [2:0]        cmd;
    logic              excl;
    logic [1:0]        src;
    logic [TIME_W-1:0] rdy;
    logic [ORD_W-1:0]  ord;
  } tgt_t;

  function automatic logic [2:0] fail_cmd(input logic [2:0] c);
    case (c)
      CMD_UPG:    fail_cmd = CMD_READ_EX;
      CMD_SC_UPG: fail_cmd = CMD_SC_UPG_FAIL;
      CMD_SC:     fail_cmd = CMD_SC_FAIL;
      default:    fail_cmd = c;
    endcase
  endfunction

  function automatic logic is_upg(input logic [2:0] c);
    is_upg = (c == CMD_UPG) || (c == CMD_SC_UPG) || (c == CMD_SC);
  endfunction
endpackage

// File: rtl/defer_policy.sv
module defer_policy
  import miss_pkg::*;
(
  input  logic       in_svc,
  input  logic       def_nonempty,
  input  logic       inv_after,
  input  logic       dg_after,
  input  logic       own_pend,
  input  logic       is_fwd,
  input  logic       t_excl,
  input  logic [1:0] t_src,
  input  logic [2:0] t_cmd,
  output logic       to_def,
  output logic [2:0] cmd_out
);
  logic excl_blocked;

  always_comb begin
    excl_blocked = t_excl && (!own_pend || dg_after || is_fwd);
    to_def  = (t_src != SRC_SNOOP) && in_svc &&
              (def_nonempty || inv_after || excl_blocked);
    cmd_out = (to_def && inv_after) ? fail_cmd(t_cmd) : t_cmd;
  end
endmodule

// File: rtl/tgt_queue.sv
module tgt_queue
  import miss_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  tgt_t                  push_item,
  input  logic                  pop,
  input  logic                  repl,
  input  logic                  clear,
  input  logic                  flags_clr,
  input  logic                  load,
  input  tgt_t [DEPTH-1:0]      load_items,
  input  logic [CW-1:0]         load_cnt,
  input  logic                  load_excl,
  input  logic                  load_upg,
  input  logic                  force_excl,
  output tgt_t [DEPTH-1:0]      items,
  output logic [CW-1:0]         count,
  output logic                  needs_excl,
  output logic                  has_upg,
  output logic                  full,
  output logic                  ovf
);
  tgt_t [DEPTH-1:0] mem_q, mem_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             excl_q, excl_n, upg_q, upg_n, stored;
  int               tot;

  always_comb begin
    mem_n  = mem_q;
    cnt_n  = cnt_q;
    ovf    = 1'b0;
    stored = 1'b0;
    tot    = 0;
    if (repl && upg_q) begin
      for (int i = 0; i < DEPTH; i++) mem_n[i].cmd = fail_cmd(mem_q[i].cmd);
    end
    if (clear) cnt_n = '0;
    if (pop && cnt_n != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_n[i+1];
      cnt_n = cnt_n - CW'(1);
    end
    if (load) begin
      tot = int'(cnt_n) + int'(load_cnt);
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(cnt_n) && i < tot) mem_n[i] = load_items[IW'(i - int'(cnt_n))];
      end
      if (tot > DEPTH) begin
        ovf   = 1'b1;
        cnt_n = CW'(DEPTH);
      end else begin
        cnt_n = CW'(tot);
      end
    end
    if (push) begin
      if (int'(cnt_n) == DEPTH) begin
        ovf = 1'b1;
      end else begin
        mem_n[IW'(cnt_n)] = push_item;
        cnt_n  = cnt_n + CW'(1);
        stored = 1'b1;
      end
    end
    excl_n = (flags_clr ? 1'b0 : excl_q) | (load & load_excl) | force_excl |
             (stored & (push_item.src != SRC_SNOOP) & push_item.excl);
    upg_n  = ((flags_clr | (repl & upg_q)) ? 1'b0 : upg_q) | (load & load_upg) |
             (stored & (push_item.src != SRC_SNOOP) & is_upg(push_item.cmd));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q  <= '0;
      cnt_q  <= '0;
      excl_q <= 1'b0;
      upg_q  <= 1'b0;
    end else begin
      mem_q  <= mem_n;
      cnt_q  <= cnt_n;
      excl_q <= excl_n;
      upg_q  <= upg_n;
    end
  end

  assign items      = mem_q;
  assign count      = cnt_q;
  assign needs_excl = excl_q;
  assign has_upg    = upg_q;
  assign full       = (int'(cnt_q) == DEPTH);

  // R6
  repl_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl && !has_upg && !pop && !push && !load && !clear |=> $stable(mem_q));

  // R12
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !load && !clear |=> int'(cnt_q) == DEPTH);
endmodule

// File: rtl/miss_entry.sv
module miss_entry
  import miss_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int ADDR_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_fwd,
  input  logic              alloc_noresp,
  input  logic              svc_dirty,
  input  logic              fill_shared,
  input  logic [TIME_W-1:0] now_time,
  input  logic              tgt_valid,
  output logic              tgt_ready,
  input  logic [2:0]        tgt_cmd,
  input  logic              tgt_excl,
  input  logic [1:0]        tgt_src,
  input  logic [TIME_W-1:0] tgt_time,
  input  logic [ORD_W-1:0]  tgt_order,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_cmd,
  output logic              out_excl,
  output logic [1:0]        out_src,
  output logic [TIME_W-1:0] out_time,
  output logic [ORD_W-1:0]  out_order,
  output logic              in_service,
  output logic              pending_dirty,
  output logic              post_inval,
  output logic              post_downgr,
  output logic              ds_pending,
  output logic              fwd_done,
  output logic              err,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [TIME_W-1:0] entry_time,
  output logic [ORD_W-1:0]  entry_order,
  output logic [CW-1:0]     prim_count,
  output logic [CW-1:0]     def_count,
  output logic              prim_excl,
  output logic              prim_upg,
  output logic              def_excl,
  output logic              def_upg
);
  tgt_t [DEPTH-1:0] p_items, d_items;
  logic p_full, d_full, p_ovf, d_ovf;
  logic fwd_q, noresp_q;
  logic push_ok, pop_ok, to_def, is_alloc, is_svc, is_fill, is_promo, is_dealloc;
  logic fwd_nr_svc, merge, promo, dealloc_ok;
  logic [2:0] routed_cmd;
  tgt_t push_item, p_push_item;

  assign tgt_ready = !op_valid;
  assign out_valid = !op_valid && (prim_count != '0);
  assign push_ok   = tgt_valid && tgt_ready;
  assign pop_ok    = out_valid && out_ready;

  assign is_alloc   = op_valid && (op_code == OP_ALLOC);
  assign is_svc     = op_valid && (op_code == OP_SERVICE);
  assign is_fill    = op_valid && (op_code == OP_FILL);
  assign is_promo   = op_valid && (op_code == OP_PROMOTE);
  assign is_dealloc = op_valid && (op_code == OP_DEALLOC);

  assign fwd_nr_svc = is_svc && !in_service && fwd_q && noresp_q;
  assign merge      = is_fill && !fill_shared && !post_inval && !post_downgr && def_excl;
  assign promo      = is_promo && (prim_count == '0) && (def_count != '0);
  assign dealloc_ok = is_dealloc && (prim_count == '0);

  defer_policy u_policy (
    .in_svc       (in_service),
    .def_nonempty (def_count != '0),
    .inv_after    (post_inval),
    .dg_after     (post_downgr),
    .own_pend     (pending_dirty),
    .is_fwd       (fwd_q),
    .t_excl       (tgt_excl),
    .t_src        (tgt_src),
    .t_cmd        (tgt_cmd),
    .to_def       (to_def),
    .cmd_out      (routed_cmd)
  );

  always_comb begin
    push_item = '{cmd: routed_cmd, excl: tgt_excl, src: tgt_src, rdy: tgt_time, ord: tgt_order};
    p_push_item = push_item;
    if (is_alloc) begin
      p_push_item.cmd = tgt_cmd;
      p_push_item.src = (tgt_cmd == CMD_HWPF) ? SRC_PREF : SRC_CPU;
    end
  end

  tgt_queue #(.DEPTH(DEPTH)) u_prim (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       ((push_ok && !to_def) || is_alloc),
    .push_item  (p_push_item),
    .pop        (pop_ok || fwd_nr_svc),
    .repl       (op_valid && (op_code == OP_REPL_ALL)),
    .clear      (1'b0),
    .flags_clr  (promo || dealloc_ok),
    .load       (merge || promo),
    .load_items (d_items),
    .load_cnt   (def_count),
    .load_excl  (def_excl),
    .load_upg   (def_upg),
    .force_excl (merge),
    .items      (p_items),
    .count      (prim_count),
    .needs_excl (prim_excl),
    .has_upg    (prim_upg),
    .full       (p_full),
    .ovf        (p_ovf)
  );

  tgt_queue #(.DEPTH(DEPTH)) u_def (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_ok && to_def),
    .push_item  (push_item),
    .pop        (1'b0),
    .repl       (op_valid && ((op_code == OP_REPL_ALL) || (op_code == OP_SNP_INV))),
    .clear      (merge || promo),
    .flags_clr  (merge || promo),
    .load       (1'b0),
    .load_items (p_items),
    .load_cnt   ('0),
    .load_excl  (1'b0),
    .load_upg   (1'b0),
    .force_excl (1'b0),
    .items      (d_items),
    .count      (def_count),
    .needs_excl (def_excl),
    .has_upg    (def_upg),
    .full       (d_full),
    .ovf        (d_ovf)
  );

  assign out_cmd   = p_items[0].cmd;
  assign out_excl  = p_items[0].excl;
  assign out_src   = p_items[0].src;
  assign out_time  = p_items[0].rdy;
  assign out_order = p_items[0].ord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_addr      <= '0;
      entry_time    <= '0;
      entry_order   <= '0;
      fwd_q         <= 1'b0;
      noresp_q      <= 1'b0;
      in_service    <= 1'b0;
      pending_dirty <= 1'b0;
      post_inval    <= 1'b0;
      post_downgr   <= 1'b0;
      ds_pending    <= 1'b0;
      fwd_done      <= 1'b0;
      err           <= 1'b0;
    end else begin
      fwd_done <= fwd_nr_svc;
      err      <= err | p_ovf | d_ovf;
      if (op_valid) begin
        case (op_code)
          OP_ALLOC: begin
            blk_addr    <= alloc_addr;
            entry_time  <= tgt_time;
            entry_order <= tgt_order;
            fwd_q       <= alloc_fwd;
            noresp_q    <= alloc_noresp;
            in_service  <= 1'b0;
            ds_pending  <= 1'b0;
          end
          OP_SERVICE: begin
            if (!in_service && !(fwd_q && noresp_q)) begin
              in_service    <= 1'b1;
              pending_dirty <= prim_excl | svc_dirty;
              post_inval    <= 1'b0;
              post_downgr   <= 1'b0;
            end
          end
          OP_PROMOTE: begin
            if (promo) begin
              entry_order <= d_items[0].ord;
              entry_time  <= (now_time > d_items[0].rdy) ? now_time : d_items[0].rdy;
            end
          end
          OP_DEALLOC: if (dealloc_ok) in_service <= 1'b0;
          OP_SNP_INV: post_inval  <= 1'b1;
          OP_SNP_SHR: post_downgr <= 1'b1;
          OP_DSP_SET: ds_pending  <= 1'b1;
          OP_DSP_CLR: ds_pending  <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R7
  svc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_svc && !in_service && !(fwd_q && noresp_q) |=> in_service && !post_inval && !post_downgr);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  promo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_promo && prim_count != '0 |=> prim_count == $past(prim_count) && def_count == $past(def_count));

  // R11
  dealloc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_dealloc && prim_count != '0 |=> in_service == $past(in_service));

  // R3
  defer_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && tgt_src != SRC_SNOOP && in_service && def_count != '0 && !d_full
    |=> def_count == $past(def_count) + CW'(1));
endmodule

// File: tb/miss_entry_test.sv
module miss_entry_test;
  import miss_pkg::*;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [AW-1:0] alloc_addr = '0;
  logic alloc_fwd = 1'b0, alloc_noresp = 1'b0, svc_dirty = 1'b0, fill_shared = 1'b0;
  logic [TIME_W-1:0] now_time = '0;
  logic tgt_valid = 1'b0, tgt_ready;
  logic [2:0] tgt_cmd = '0;
  logic tgt_excl = 1'b0;
  logic [1:0] tgt_src = '0;
  logic [TIME_W-1:0] tgt_time = '0;
  logic [ORD_W-1:0] tgt_order = '0;
  logic out_valid, out_ready = 1'b0;
  logic [2:0] out_cmd;
  logic out_excl;
  logic [1:0] out_src;
  logic [TIME_W-1:0] out_time;
  logic [ORD_W-1:0] out_order;
  logic in_service, pending_dirty, post_inval, post_downgr, ds_pending, fwd_done, err;
  logic [AW-1:0] blk_addr;
  logic [TIME_W-1:0] entry_time;
  logic [ORD_W-1:0] entry_order;
  logic [CW-1:0] prim_count, def_count;
  logic prim_excl, prim_upg, def_excl, def_upg;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [29:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  miss_entry #(.DEPTH(DEPTH), .ADDR_W(AW)) uut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_item(string req, int cmd, int excl, int src, int t, int o);
    exp_q.push_back({3'(cmd), 1'(excl), 2'(src), TIME_W'(t), ORD_W'(o)});
    tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R13: unexpected target actual %0h expected none",
                 {out_cmd, out_excl, out_src, out_time, out_order});
      end else begin
        automatic logic [29:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if ({out_cmd, out_excl, out_src, out_time, out_order} != e) begin
          n_bad++;
          $display("FAIL %s: target actual %0h expected %0h", t,
                   {out_cmd, out_excl, out_src, out_time, out_order}, e);
        end
      end
    end
  end

  task automatic do_op(op_e op);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_tgt(int cmd, int excl, int src, int t, int o);
    tgt_cmd = 3'(cmd); tgt_excl = 1'(excl); tgt_src = 2'(src);
    tgt_time = TIME_W'(t); tgt_order = ORD_W'(o);
  endtask

  task automatic alloc(int addr, int cmd, int t, int o, bit fwd, bit nr);
    set_tgt(cmd, 0, 0, t, o);
    alloc_addr = AW'(addr); alloc_fwd = fwd; alloc_noresp = nr;
    do_op(OP_ALLOC);
    alloc_fwd = 1'b0; alloc_noresp = 1'b0;
  endtask

  task automatic push(int cmd, int excl, int src, int t, int o);
    @(negedge clk);
    set_tgt(cmd, excl, src, t, o);
    tgt_valid = 1'b1;
    @(negedge clk);
    tgt_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    out_ready = 1'b1;
    while (prim_count != '0) @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_service", in_service, 0);
    chk("R1 prim_count", prim_count, 0);
    chk("R1 def_count", def_count, 0);
    chk("R1 err", err, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 flags", {pending_dirty, post_inval, post_downgr, ds_pending, prim_excl, prim_upg}, 0);

    // R2 allocate with prefetch command
    alloc(32'h1000, 7, 5, 1, 0, 0);
    chk("R2 blk_addr", blk_addr, 32'h1000);
    chk("R2 entry_time", entry_time, 5);
    chk("R2 entry_order", entry_order, 1);
    chk("R2 in_service", in_service, 0);
    expect_item("R2", 7, 0, 2, 5, 1);
    push(0, 0, 0, 6, 2);
    chk("R3 not in service goes primary", prim_count, 2);
    expect_item("R3", 0, 0, 0, 6, 2);
    drain();

    // R5 snoop-sourced upgrade leaves summary bits clear; R6 skip when clear
    push(2, 1, 1, 7, 3);
    chk("R5 snoop excl", prim_excl, 0);
    chk("R5 snoop upg", prim_upg, 0);
    do_op(OP_REPL_ALL);
    expect_item("R6 skip", 2, 1, 1, 7, 3);
    drain();
    push(2, 1, 0, 8, 4);
    chk("R5 cpu excl", prim_excl, 1);
    chk("R5 cpu upg", prim_upg, 1);
    do_op(OP_REPL_ALL);
    chk("R6 upg cleared", prim_upg, 0);
    expect_item("R6 rewrite", 1, 1, 0, 8, 4);
    drain();
    do_op(OP_DEALLOC);
    chk("R11 flags reset", prim_excl, 0);
    chk("R11 in_service", in_service, 0);

    // R7 service, R3 deferral, R9 merge
    alloc(32'h2000, 0, 10, 2, 0, 0);
    expect_item("R9", 0, 0, 0, 10, 2);
    svc_dirty = 1'b0;
    do_op(OP_SERVICE);
    chk("R7 in_service", in_service, 1);
    chk("R7 pending_dirty", pending_dirty, 0);
    push(1, 1, 0, 11, 5);
    chk("R3 excl without ownership deferred", def_count, 1);
    chk("R3 primary unchanged", prim_count, 1);
    push(0, 0, 0, 12, 6);
    chk("R3 behind deferred", def_count, 2);
    expect_item("R9", 1, 1, 0, 11, 5);
    expect_item("R9", 0, 0, 0, 12, 6);
    fill_shared = 1'b0;
    do_op(OP_FILL);
    chk("R9 merged prim", prim_count, 3);
    chk("R9 merged def", def_count, 0);
    chk("R9 prim excl", prim_excl, 1);
    chk("R9 def excl reset", def_excl, 0);
    drain();
    do_op(OP_DEALLOC);
    chk("R11 dealloc", in_service, 0);

    // R7 dirty input, R11 blocked dealloc, R4 rewrite, R10 promotion
    alloc(32'h3000, 0, 20, 7, 0, 0);
    expect_item("R10", 0, 0, 0, 20, 7);
    svc_dirty = 1'b1;
    do_op(OP_SERVICE);
    svc_dirty = 1'b0;
    chk("R7 dirty input", pending_dirty, 1);
    do_op(OP_DEALLOC);
    chk("R11 blocked", in_service, 1);
    do_op(OP_SNP_SHR);
    chk("R14 post_downgr", post_downgr, 1);
    push(1, 1, 0, 21, 8);
    chk("R3 post-downgrade deferred", def_count, 1);
    do_op(OP_SNP_INV);
    chk("R14 post_inval", post_inval, 1);
    push(2, 1, 0, 22, 9);
    push(4, 0, 0, 23, 10);
    push(3, 1, 0, 24, 11);
    chk("R4 deferred count", def_count, 4);
    do_op(OP_FILL);
    chk("R9 no merge def", def_count, 4);
    chk("R9 no merge prim", prim_count, 1);
    do_op(OP_PROMOTE);
    chk("R10 blocked", def_count, 4);
    drain();
    now_time = 3;
    do_op(OP_PROMOTE);
    chk("R10 time", entry_time, 21);
    chk("R10 order", entry_order, 8);
    chk("R10 prim count", prim_count, 4);
    chk("R10 def count", def_count, 0);
    chk("R10 excl moved", prim_excl, 1);
    expect_item("R4", 1, 1, 0, 21, 8);
    expect_item("R4", 1, 1, 0, 22, 9);
    expect_item("R4", 6, 0, 0, 23, 10);
    expect_item("R4", 5, 1, 0, 24, 11);
    drain();
    do_op(OP_DEALLOC);
    alloc(32'h4000, 0, 30, 12, 0, 0);
    expect_item("R7", 0, 0, 0, 30, 12);
    do_op(OP_SERVICE);
    chk("R7 post_inval cleared", post_inval, 0);
    chk("R7 post_downgr cleared", post_downgr, 0);
    drain();
    do_op(OP_DEALLOC);

    // R8 forward without response
    alloc(32'h5000, 0, 40, 13, 1, 1);
    do_op(OP_SERVICE);
    chk("R8 fwd_done", fwd_done, 1);
    chk("R8 popped", prim_count, 0);
    chk("R8 not in service", in_service, 0);

    // R14 downstream pending
    do_op(OP_DSP_SET);
    chk("R14 set", ds_pending, 1);
    do_op(OP_DSP_CLR);
    chk("R14 clr", ds_pending, 0);
    do_op(OP_DSP_SET);
    alloc(32'h6000, 0, 50, 14, 0, 0);
    chk("R2 ds cleared", ds_pending, 0);
    expect_item("R12", 0, 0, 0, 50, 14);

    // R13 back-pressure during operation cycles
    @(negedge clk);
    op_valid = 1'b1; op_code = OP_SNP_SHR;
    #1;
    chk("R13 tgt_ready low", tgt_ready, 0);
    chk("R13 out_valid low", out_valid, 0);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk("R13 out_valid high", out_valid, 1);

    // R12 overflow
    for (int i = 0; i < 8; i++) begin
      push(0, 0, 0, 60 + i, 20 + i);
      if (i < 7) expect_item("R12", 0, 0, 0, 60 + i, 20 + i);
    end
    chk("R12 count", prim_count, 8);
    chk("R12 err", err, 1);
    drain();
    chk("R12 err sticky", err, 1);
    chk("R13 all targets seen", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule